// File: doc/BRIEF.md
# Load/Store Execution Unit with Alignment Trap

This unit carries out one memory access at a time for a 32-bit integer pipeline. It receives a decoded operation: direction, access size, a base register value, a signed 16-bit offset, the destination register index and the store value. It forms the effective address from these. Byte, halfword and word transfers go out over a little-endian, byte-addressed memory port. That port has a request/ready handshake and per-lane byte enables.

Loaded values are zero-extended and returned through a register write-back port. Stores send the low bits of the store value on the lanes that the address selects.

Before it touches memory, the unit checks natural alignment for halfword and word accesses. A misaligned access produces a one-cycle trap carrying the faulting address. A trapped access makes no memory request and no register write. Only one operation is in flight at a time. The unit signals readiness for the next operation while it is idle.

Top module: `lsu_core`

## Requirements
- R1: The effective address is `op_base` plus `op_imm` sign-extended to 32 bits; `mem_addr` carries that address with bits 1:0 forced to zero.
- R2: `op_size` encodes 00 = byte, 01 = halfword, 10 or 11 = word; an operation is taken when `op_valid` and `op_ready` are both high, and `op_ready` is high only while no access is outstanding.
- R3: A byte load writes back lane k of `mem_rdata` (bits 8k+7:8k, k = address bits 1:0), zero-extended to 32 bits.
- R4: A halfword load writes back bits 16j+15:16j of `mem_rdata` (j = address bit 1), zero-extended to 32 bits.
- R5: A word load writes back all 32 bits of `mem_rdata`.
- R6: A store drives `mem_we` high and `mem_be` = 0001 shifted left by address bits 1:0 for a byte, 0011 shifted left by address bits 1:0 for a halfword, and 1111 for a word. The low 8, 16 or 32 bits of `op_wdata` appear on the enabled lanes, least significant byte in the lowest enabled lane.
- R7: A halfword access with address bit 0 set traps. A word access with address bits 1:0 nonzero traps. A byte access never traps.
- R8: A trapping operation raises `trap_unaligned` for exactly one cycle, the cycle after it is taken, with `trap_addr` equal to the effective address. It issues no memory request, asserts neither `wb_en` nor `done`, and leaves `op_ready` high.
- R9: A non-trapping operation raises `mem_req` in the cycle after it is taken. It holds `mem_req`, `mem_addr`, `mem_be`, `mem_we` and `mem_wdata` unchanged until a clock edge at which `mem_ready` is high.
- R10: One cycle after the completing edge, `done` pulses for one cycle. For a load, `wb_en` is high in that same cycle with `wb_idx` equal to the operation's `op_dst` and `wb_data` holding the loaded value. A store never asserts `wb_en`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| op_valid | input | 1 | Operation offered |
| op_ready | output | 1 | Unit idle, operation can be taken |
| op_store | input | 1 | 1 = store, 0 = load |
| op_size | input | 2 | Access size code |
| op_base | input | 32 | Base register value |
| op_imm | input | 16 | Signed address offset |
| op_dst | input | 5 | Register index for load result |
| op_wdata | input | 32 | Store register value |
| mem_req | output | 1 | Memory request |
| mem_we | output | 1 | Request is a write |
| mem_addr | output | 32 | Word-aligned request address |
| mem_be | output | 4 | Lane enables |
| mem_wdata | output | 32 | Lane-placed write data |
| mem_ready | input | 1 | Memory completes the request |
| mem_rdata | input | 32 | Read word, valid with mem_ready |
| done | output | 1 | Access completed |
| wb_en | output | 1 | Register write-back strobe |
| wb_idx | output | 5 | Write-back register index |
| wb_data | output | 32 | Write-back value |
| trap_unaligned | output | 1 | Misaligned access trap |
| trap_addr | output | 32 | Faulting effective address |

## Verification
A wrong lane offset or a wrong latched size shows up at the ports in two ways. It can put a misplaced byte enable on the very request the unit issues. It can also put a shifted or unmasked value on `wb_data` in the `done` cycle. The memory model and scoreboard catch both on that access.

A corrupted busy state would either drop `mem_req` before the handshake or keep `op_ready` low after it. Either shows as a stability miss or a stall within a cycle or two. A faulty alignment check appears either as a trap where a completion was expected or as an unexpected request reaching the memory model. In both cases the discrepancy is visible in the cycle right after the operation is taken.

// File: rtl/lsu_pkg.sv
package lsu_pkg;
  localparam int unsigned LSU_DATA_W = 32;
  localparam int unsigned LSU_LANES  = LSU_DATA_W / 8;
  localparam int unsigned LSU_OFF_W  = $clog2(LSU_LANES);

  typedef enum logic [1:0] {
    SZ_BYTE = 2'b00,
    SZ_HALF = 2'b01,
    SZ_WORD = 2'b10
  } lsu_size_e;

  typedef enum logic {
    ST_IDLE = 1'b0,
    ST_BUSY = 1'b1
  } lsu_state_e;

  function automatic lsu_size_e size_decode(input logic [1:0] code);
    if (code[1])            return SZ_WORD;
    else if (code[0])       return SZ_HALF;
    else                    return SZ_BYTE;
  endfunction
endpackage

// File: rtl/lsu_agen.sv
module lsu_agen
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 16
) (
  input  logic [ADDR_W-1:0] base,
  input  logic [IMM_W-1:0]  imm,
  input  logic [1:0]        size_code,
  output logic [ADDR_W-1:0] ea,
  output logic              misalign
);
  localparam int unsigned EXT_W = ADDR_W - IMM_W;

  lsu_size_e sz;

  always_comb begin
    ea = base + {{EXT_W{imm[IMM_W-1]}}, imm};
    sz = size_decode(size_code);
    unique case (sz)
      SZ_HALF: misalign = ea[0];
      SZ_WORD: misalign = |ea[LSU_OFF_W-1:0];
      default: misalign = 1'b0;
    endcase
  end
endmodule

// File: rtl/lsu_lanes.sv
module lsu_lanes
  import lsu_pkg::*;
(
  input  lsu_size_e               sz,
  input  logic [LSU_OFF_W-1:0]    off,
  input  logic [LSU_DATA_W-1:0]   sdata,
  input  logic [LSU_DATA_W-1:0]   rdata,
  output logic [LSU_LANES-1:0]    be,
  output logic [LSU_DATA_W-1:0]   wdata,
  output logic [LSU_DATA_W-1:0]   load_val
);
  for (genvar k = 0; k < LSU_LANES; k++) begin : g_lane
    localparam int unsigned HALF_POS = k % 2;
    always_comb begin
      unique case (sz)
        SZ_BYTE: begin
          be[k]          = (off == LSU_OFF_W'(k));
          wdata[8*k +: 8] = sdata[7:0];
        end
        SZ_HALF: begin
          be[k]          = (off[LSU_OFF_W-1] == logic'(k / 2));
          wdata[8*k +: 8] = sdata[8*HALF_POS +: 8];
        end
        default: begin
          be[k]          = 1'b1;
          wdata[8*k +: 8] = sdata[8*k +: 8];
        end
      endcase
    end
  end

  always_comb begin
    load_val = '0;
    unique case (sz)
      SZ_BYTE: load_val[7:0]  = rdata[8*off +: 8];
      SZ_HALF: load_val[15:0] = rdata[16*off[LSU_OFF_W-1] +: 16];
      default: load_val       = rdata;
    endcase
  end
endmodule

// File: rtl/lsu_ctrl.sv
module lsu_ctrl
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  input  logic                  op_store,
  input  logic [1:0]            op_size,
  input  logic [IDX_W-1:0]      op_dst,
  input  logic [LSU_DATA_W-1:0] op_wdata,
  input  logic [ADDR_W-1:0]     ea,
  input  logic                  misalign,
  input  logic                  mem_ready,
  input  logic [LSU_DATA_W-1:0] load_val,
  output logic                  op_ready,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output lsu_size_e             cur_sz,
  output logic [LSU_OFF_W-1:0]  cur_off,
  output logic [LSU_DATA_W-1:0] cur_sdata,
  output logic                  done,
  output logic                  wb_en,
  output logic [IDX_W-1:0]      wb_idx,
  output logic [LSU_DATA_W-1:0] wb_data,
  output logic                  trap_unaligned,
  output logic [ADDR_W-1:0]     trap_addr
);
  lsu_state_e state_q, state_d;
  logic       take, finish;
  logic       load_en, trap_en;
  logic       done_d, wbe_d, trap_d;

  logic [ADDR_W-1:0]     ea_q;
  lsu_size_e             sz_q;
  logic                  st_q;
  logic [IDX_W-1:0]      idx_q;
  logic [LSU_DATA_W-1:0] sd_q;

  always_comb begin
    take    = op_valid && (state_q == ST_IDLE);
    finish  = (state_q == ST_BUSY) && mem_ready;
    load_en = take && !misalign;
    trap_en = take && misalign;
    state_d = state_q;
    if (load_en)     state_d = ST_BUSY;
    else if (finish) state_d = ST_IDLE;
    trap_d  = trap_en;
    done_d  = finish;
    wbe_d   = finish && !st_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q        <= ST_IDLE;
      trap_unaligned <= 1'b0;
      done           <= 1'b0;
      wb_en          <= 1'b0;
    end else begin
      state_q        <= state_d;
      trap_unaligned <= trap_d;
      done           <= done_d;
      wb_en          <= wbe_d;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ea_q  <= '0;
      sz_q  <= SZ_BYTE;
      st_q  <= 1'b0;
      idx_q <= '0;
      sd_q  <= '0;
    end else if (load_en) begin
      ea_q  <= ea;
      sz_q  <= size_decode(op_size);
      st_q  <= op_store;
      idx_q <= op_dst;
      sd_q  <= op_wdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      trap_addr <= '0;
    end else if (trap_en) begin
      trap_addr <= ea;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wb_idx  <= '0;
      wb_data <= '0;
    end else if (finish && !st_q) begin
      wb_idx  <= idx_q;
      wb_data <= load_val;
    end
  end

  always_comb begin
    op_ready  = (state_q == ST_IDLE);
    mem_req   = (state_q == ST_BUSY);
    mem_we    = st_q;
    mem_addr  = {ea_q[ADDR_W-1:LSU_OFF_W], {LSU_OFF_W{1'b0}}};
    cur_sz    = sz_q;
    cur_off   = ea_q[LSU_OFF_W-1:0];
    cur_sdata = sd_q;
  end
endmodule

// File: rtl/lsu_core.sv
module lsu_core
  import lsu_pkg::*;
#(
  parameter int unsigned ADDR_W = 32,
  parameter int unsigned IMM_W  = 16,
  parameter int unsigned IDX_W  = 5
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  op_valid,
  output logic                  op_ready,
  input  logic                  op_store,
  input  logic [1:0]            op_size,
  input  logic [ADDR_W-1:0]     op_base,
  input  logic [IMM_W-1:0]      op_imm,
  input  logic [IDX_W-1:0]      op_dst,
  input  logic [LSU_DATA_W-1:0] op_wdata,
  output logic                  mem_req,
  output logic                  mem_we,
  output logic [ADDR_W-1:0]     mem_addr,
  output logic [LSU_LANES-1:0]  mem_be,
  output logic [LSU_DATA_W-1:0] mem_wdata,
  input  logic                  mem_ready,
  input  logic [LSU_DATA_W-1:0] mem_rdata,
  output logic                  done,
  output logic                  wb_en,
  output logic [IDX_W-1:0]      wb_idx,
  output logic [LSU_DATA_W-1:0] wb_data,
  output logic                  trap_unaligned,
  output logic [ADDR_W-1:0]     trap_addr
);
  logic [ADDR_W-1:0]     ea;
  logic                  misalign;
  lsu_size_e             cur_sz;
  logic [LSU_OFF_W-1:0]  cur_off;
  logic [LSU_DATA_W-1:0] cur_sdata;
  logic [LSU_DATA_W-1:0] load_val;

  lsu_agen #(.ADDR_W(ADDR_W), .IMM_W(IMM_W)) agen_i (
    .base      (op_base),
    .imm       (op_imm),
    .size_code (op_size),
    .ea        (ea),
    .misalign  (misalign)
  );

  lsu_ctrl #(.ADDR_W(ADDR_W), .IDX_W(IDX_W)) ctrl_i (
    .clk            (clk),
    .rst_n          (rst_n),
    .op_valid       (op_valid),
    .op_store       (op_store),
    .op_size        (op_size),
    .op_dst         (op_dst),
    .op_wdata       (op_wdata),
    .ea             (ea),
    .misalign       (misalign),
    .mem_ready      (mem_ready),
    .load_val       (load_val),
    .op_ready       (op_ready),
    .mem_req        (mem_req),
    .mem_we         (mem_we),
    .mem_addr       (mem_addr),
    .cur_sz         (cur_sz),
    .cur_off        (cur_off),
    .cur_sdata      (cur_sdata),
    .done           (done),
    .wb_en          (wb_en),
    .wb_idx         (wb_idx),
    .wb_data        (wb_data),
    .trap_unaligned (trap_unaligned),
    .trap_addr      (trap_addr)
  );

  lsu_lanes lanes_i (
    .sz       (cur_sz),
    .off      (cur_off),
    .sdata    (cur_sdata),
    .rdata    (mem_rdata),
    .be       (mem_be),
    .wdata    (mem_wdata),
    .load_val (load_val)
  );
endmodule

// File: rtl/lsu_core_chk.sv
module lsu_core_chk #(
  parameter int unsigned ADDR_W = 32
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_ready,
  input logic              mem_req,
  input logic              mem_we,
  input logic [ADDR_W-1:0] mem_addr,
  input logic [3:0]        mem_be,
  input logic [31:0]       mem_wdata,
  input logic              mem_ready,
  input logic              done,
  input logic              wb_en,
  input logic              trap_unaligned
);
  AST_ADDR_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> (mem_addr[1:0] == 2'b00)); // R1

  AST_BUSY_NOT_READY: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> !op_ready); // R2

  AST_BE_SHAPE: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> ($countones(mem_be) == 1 || $countones(mem_be) == 2 || $countones(mem_be) == 4)); // R6

  AST_TRAP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    trap_unaligned |-> (!mem_req && !wb_en && !done && op_ready)); // R8

  AST_REQ_HELD: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> mem_req); // R9

  AST_REQ_STABLE: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_ready) |=> ($stable(mem_addr) && $stable(mem_be) && $stable(mem_we) && $stable(mem_wdata))); // R9

  AST_DONE_AFTER_HS: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> $past(mem_req && mem_ready)); // R10

  AST_WB_LOAD_ONLY: assert property (@(posedge clk) disable iff (!rst_n)
    wb_en |-> (done && !$past(mem_we))); // R10
endmodule

bind lsu_core lsu_core_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk            (clk),
  .rst_n          (rst_n),
  .op_ready       (op_ready),
  .mem_req        (mem_req),
  .mem_we         (mem_we),
  .mem_addr       (mem_addr),
  .mem_be         (mem_be),
  .mem_wdata      (mem_wdata),
  .mem_ready      (mem_ready),
  .done           (done),
  .wb_en          (wb_en),
  .trap_unaligned (trap_unaligned)
);

// File: tb/lsu_core_tb_top.sv
module lsu_core_tb_top;
  logic        clk;
  logic        rst_n;
  logic        op_valid, op_ready, op_store;
  logic [1:0]  op_size;
  logic [31:0] op_base;
  logic [15:0] op_imm;
  logic [4:0]  op_dst;
  logic [31:0] op_wdata;
  logic        mem_req, mem_we, mem_ready;
  logic [31:0] mem_addr, mem_wdata, mem_rdata;
  logic [3:0]  mem_be;
  logic        done, wb_en, trap_unaligned;
  logic [4:0]  wb_idx;
  logic [31:0] wb_data, trap_addr;

  int errors = 0;
  int checks = 0;
  bit finished = 0;

  typedef struct {
    bit          is_trap;
    logic [31:0] addr;
    bit          wb;
    logic [4:0]  idx;
    logic [31:0] data;
  } sb_item_t;

  typedef struct {
    bit          we;
    logic [31:0] addr;
    logic [3:0]  be;
    logic [31:0] wd;
  } req_item_t;

  sb_item_t  sb_q[$];
  req_item_t req_q[$];

  logic [31:0] mem_words [16];
  logic [31:0] ref_words [16];

  initial clk = 1'b0;
  always #10 clk = ~clk;

  lsu_core dut_i (
    .clk(clk), .rst_n(rst_n),
    .op_valid(op_valid), .op_ready(op_ready), .op_store(op_store),
    .op_size(op_size), .op_base(op_base), .op_imm(op_imm),
    .op_dst(op_dst), .op_wdata(op_wdata),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_be(mem_be), .mem_wdata(mem_wdata), .mem_ready(mem_ready),
    .mem_rdata(mem_rdata), .done(done), .wb_en(wb_en), .wb_idx(wb_idx),
    .wb_data(wb_data), .trap_unaligned(trap_unaligned), .trap_addr(trap_addr)
  );

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  function automatic logic [31:0] lane_mask(input logic [3:0] be);
    logic [31:0] m;
    for (int k = 0; k < 4; k++) m[8*k +: 8] = {8{be[k]}};
    return m;
  endfunction

  // Driver: offers one operation and pushes its expected results.
  task automatic do_op(input bit st, input logic [1:0] sz, input logic [31:0] base,
                       input logic [15:0] imm, input logic [4:0] dst, input logic [31:0] sd);
    logic [31:0] ea;
    logic [1:0]  off;
    bit          bad;
    logic [3:0]  be;
    logic [31:0] w, ld;
    sb_item_t    s;
    req_item_t   r;
    ea  = base + {{16{imm[15]}}, imm};
    off = ea[1:0];
    bad = (sz == 2'b01) ? off[0] : (sz[1] ? (off != 2'b00) : 1'b0);
    be  = (sz == 2'b00) ? (4'b0001 << off) : (sz == 2'b01) ? (4'b0011 << off) : 4'b1111;
    while (!op_ready) @(negedge clk);
    op_valid = 1'b1; op_store = st; op_size = sz; op_base = base;
    op_imm = imm; op_dst = dst; op_wdata = sd;
    s = '{is_trap: bad, addr: ea, wb: 1'b0, idx: dst, data: 32'h0};
    if (!bad) begin
      w = ref_words[ea[5:2]];
      if (sz == 2'b00)      ld = (w >> (8 * off)) & 32'h0000_00FF;
      else if (sz == 2'b01) ld = (w >> (16 * off[1])) & 32'h0000_FFFF;
      else                  ld = w;
      r = '{we: st, addr: {ea[31:2], 2'b00}, be: be, wd: sd << (8 * off)};
      req_q.push_back(r);
      if (st) begin
        for (int k = 0; k < 4; k++)
          if (be[k]) ref_words[ea[5:2]][8*k +: 8] = r.wd[8*k +: 8];
      end else begin
        s.wb = 1'b1; s.data = ld;
      end
    end
    sb_q.push_back(s);
    @(negedge clk);
    op_valid = 1'b0;
  endtask

  // Memory model with rotating latency; checks each request against expectations.
  int          lat_sel = 0;
  int          waited  = 0;
  bit          was_waiting = 0;
  req_item_t   held;
  initial begin
    mem_ready = 1'b0;
    mem_rdata = 32'h0;
    forever begin
      @(negedge clk);
      if (!rst_n) begin
        mem_ready = 1'b0;
        was_waiting = 0;
      end else begin
        if (was_waiting) begin
          check(mem_req && mem_addr == held.addr && mem_be == held.be && mem_we == held.we &&
                (mem_wdata & lane_mask(held.be)) == (held.wd & lane_mask(held.be)),
                "R9 request held stable", mem_addr, held.addr);
          was_waiting = 0;
        end
        if (mem_req && !mem_ready) begin
          if (waited < lat_sel) begin
            waited++;
            was_waiting = 1;
            held = '{we: mem_we, addr: mem_addr, be: mem_be, wd: mem_wdata};
          end else begin
            if (req_q.size() == 0) begin
              check(1'b0, "R8 unexpected memory request", mem_addr, 32'h0);
            end else begin
              req_item_t r;
              r = req_q.pop_front();
              check(mem_addr == r.addr, "R1 request address", mem_addr, r.addr);
              check(mem_we == r.we && mem_be == r.be, "R6 lane enables", {27'h0, mem_we, mem_be}, {27'h0, r.we, r.be});
              if (r.we)
                check((mem_wdata & lane_mask(r.be)) == (r.wd & lane_mask(r.be)),
                      "R6 store lane data", mem_wdata & lane_mask(r.be), r.wd & lane_mask(r.be));
            end
            if (mem_we) begin
              for (int k = 0; k < 4; k++)
                if (mem_be[k]) mem_words[mem_addr[5:2]][8*k +: 8] = mem_wdata[8*k +: 8];
            end
            mem_rdata = mem_we ? 32'hDEAD_BEEF : mem_words[mem_addr[5:2]];
            mem_ready = 1'b1;
            waited    = 0;
            lat_sel   = (lat_sel + 1) % 4;
          end
        end else if (!mem_req) begin
          mem_ready = 1'b0;
        end
      end
    end
  end

  // Monitor: pops the scoreboard on completions and traps.
  initial begin
    forever begin
      @(negedge clk);
      if (rst_n && (done || trap_unaligned)) begin
        if (sb_q.size() == 0) begin
          check(1'b0, "R10 unexpected completion", {31'h0, done}, 32'h0);
        end else begin
          sb_item_t s;
          s = sb_q.pop_front();
          if (s.is_trap) begin
            check(trap_unaligned && !done, "R7 trap expected", {31'h0, trap_unaligned}, 32'h1);
            check(trap_addr == s.addr, "R8 trap address", trap_addr, s.addr);
            check(!wb_en && !mem_req && op_ready, "R8 trap side effects", {29'h0, wb_en, mem_req, op_ready}, 32'h1);
          end else begin
            check(done && !trap_unaligned, "R7 no trap expected", {30'h0, done, trap_unaligned}, 32'h2);
            check(wb_en == s.wb, "R10 write-back strobe", {31'h0, wb_en}, {31'h0, s.wb});
            if (s.wb) begin
              check(wb_idx == s.idx, "R10 write-back index", {27'h0, wb_idx}, {27'h0, s.idx});
              check(wb_data == s.data, "R3 R4 R5 load value", wb_data, s.data);
            end
          end
        end
      end
    end
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!finished) begin
      errors++;
      checks++;
      $display("FAIL watchdog expired actual=%h expected=%h", 32'h0, 32'h1);
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) begin
      mem_words[i] = 32'hA1B2C3D4 ^ (i * 32'h0101_0101);
      ref_words[i] = mem_words[i];
    end
    rst_n = 1'b0; op_valid = 1'b0; op_store = 1'b0; op_size = 2'b00;
    op_base = '0; op_imm = '0; op_dst = '0; op_wdata = '0;
    repeat (3) @(negedge clk);
    check(op_ready && !mem_req && !done && !wb_en && !trap_unaligned,
          "R2 reset state", {27'h0, op_ready, mem_req, done, wb_en, trap_unaligned}, 32'h10);
    rst_n = 1'b1;
    @(negedge clk);

    // R3 byte loads at every lane
    for (int k = 0; k < 4; k++) do_op(1'b0, 2'b00, 32'h10, 16'(k), 5'(k + 1), 32'h0);
    // R4 halfword loads, R5 word load, negative offset for R1
    do_op(1'b0, 2'b01, 32'h18, 16'h0000, 5'd7, 32'h0);
    do_op(1'b0, 2'b01, 32'h18, 16'h0002, 5'd8, 32'h0);
    do_op(1'b0, 2'b10, 32'h30, 16'hFFF4, 5'd9, 32'h0);
    do_op(1'b0, 2'b11, 32'h04, 16'h0008, 5'd10, 32'h0);
    // R6 stores of each size, verified again by loads
    do_op(1'b1, 2'b10, 32'h20, 16'hFFF0, 5'd0, 32'h1122_3344);
    do_op(1'b1, 2'b00, 32'h10, 16'h0003, 5'd0, 32'hFFFF_FF5A);
    do_op(1'b1, 2'b01, 32'h10, 16'h0002, 5'd0, 32'h1234_BEEF);
    do_op(1'b1, 2'b00, 32'h14, 16'h0001, 5'd0, 32'h0000_0077);
    do_op(1'b0, 2'b10, 32'h10, 16'h0000, 5'd11, 32'h0);
    do_op(1'b0, 2'b10, 32'h14, 16'h0000, 5'd12, 32'h0);
    do_op(1'b0, 2'b00, 32'h10, 16'h0000, 5'd13, 32'h0);
    // R7 R8 misaligned accesses trap; byte at odd address does not
    do_op(1'b0, 2'b01, 32'h20, 16'h0001, 5'd14, 32'h0);
    do_op(1'b1, 2'b10, 32'h20, 16'h0002, 5'd0, 32'hCAFE_F00D);
    do_op(1'b0, 2'b11, 32'h23, 16'h0000, 5'd15, 32'h0);
    do_op(1'b1, 2'b01, 32'h28, 16'hFFFF, 5'd0, 32'h5555_AAAA);
    do_op(1'b0, 2'b00, 32'h21, 16'h0002, 5'd16, 32'h0);
    // Loads after traps confirm the trapped stores left memory untouched
    do_op(1'b0, 2'b10, 32'h20, 16'h0000, 5'd17, 32'h0);
    do_op(1'b0, 2'b10, 32'h24, 16'h0000, 5'd18, 32'h0);
    do_op(1'b0, 2'b01, 32'h3C, 16'h0002, 5'd31, 32'h0);

    repeat (12) @(negedge clk);
    check(sb_q.size() == 0 && req_q.size() == 0, "R10 all operations completed",
          sb_q.size(), 32'h0);
    check(op_ready && !mem_req, "R2 idle at end", {30'h0, op_ready, mem_req}, 32'h2);
    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule